// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request from a 32-lane warp and turns it into the smallest set of memory transactions that covers it. The request carries one byte address per lane and a mask of active lanes. Each active lane reads one 4-byte word. Memory is treated as a sequence of 128-byte segments, each aligned to 128 bytes. All active lanes whose words fall in the same segment are served by a single transaction.

The block issues the transactions one per cycle on a valid/ready port. Each transaction carries the segment base address and a mask of the lanes it serves. The number of transactions depends only on the lane address pattern:

- Lane i reading word i of an array that starts on a segment boundary costs one transaction.
- A warp that lands in 32 different segments costs 32 transactions, each carrying 4 useful bytes.

After the last transaction the block pulses a completion flag together with the number of transactions it issued. It accepts the next warp request only after that. Returning data to the lanes, caching and merging writes are done elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the next cycle until the completion cycle has ended.
- R2: The segment key of a lane is address bits [31:7]. Bits [6:0] play no part in grouping. `txn_addr` is the key with bits [6:0] zero.
- R3: All 32 lanes active, with lane i at address B+4*i and B a multiple of 128, gives exactly one transaction whose lane mask is all ones.
- R4: All 32 lanes active and contiguous as in R3, but with B not a multiple of 128, gives exactly two transactions.
- R5: All 32 lanes active in 32 different segments gives 32 transactions, each with exactly one bit set in its lane mask.
- R6: A lane whose bit in `req_mask` is 0 never appears in any `txn_lanes`. Its address has no effect on the number, order or content of the transactions.
- R7: A request with `req_mask` all zero issues no transaction. `done` is high in the cycle after acceptance, with `done_count` equal to 0.
- R8: Each transaction serves the segment of the lowest-numbered active lane not yet served. Its `txn_lanes` (bit i = lane i) holds every active, not yet served lane in that segment.
- R9: While `txn_valid` is high and `txn_ready` is low, the transaction stays presented unchanged in the next cycle.
- R10: `done` is high for exactly one cycle, in the cycle after the final transaction handshake. `done_count` equals the number of transactions issued. Every active lane is served exactly once. `req_ready` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| req_mask | input | 32 | Active-lane mask, bit i = lane i |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | 32 | Segment base byte address |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 6 | Transactions issued for the finished request |

## Verification
The assertions check the following on every cycle:

- No request is taken while one is still being served.
- A stalled transaction holds its address and lane mask.
- Every presented transaction has at least one lane.
- The set of unserved lanes only shrinks during issue.
- Lanes that have been handshaken are cleared.
- The completion pulse lasts one cycle and hands back `req_ready`.

The exact grouping and order of the transactions can only be shown by the bench's scenarios: aligned and misaligned contiguous warps, strided and interleaved patterns, fully scattered lanes, masked lanes with garbage addresses, empty masks, and random address sets with back-pressure. Each is compared against an arithmetic model of distinct segments.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } coal_state_e;

endpackage

// File: rtl/lowest_lane_pick.sv
// Finds the lowest-numbered set bit of a lane vector.
module lowest_lane_pick #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     lanes,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lanes[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/segment_match.sv
// Marks every pending lane whose address lies in the segment named by key.
module segment_match #(
    parameter int N       = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LSB = 7,
    localparam int KEY_W  = ADDR_W - SEG_LSB
) (
    input  logic [N-1:0][ADDR_W-1:0] addr,
    input  logic [N-1:0]             pend,
    input  logic [KEY_W-1:0]         key,
    output logic [N-1:0]             hit
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign hit[g] = pend[g] && (addr[g][ADDR_W-1:SEG_LSB] == key);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coalesce_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int SEG_LSB  = $clog2(SEG_BYTES),
    localparam int KEY_W    = ADDR_W - SEG_LSB,
    localparam int LEAD_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W    = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count
);

    typedef struct packed {
        coal_state_e                   state;
        logic [LANES-1:0][ADDR_W-1:0]  addr;
        logic [LANES-1:0]              pend;
        logic [CNT_W-1:0]              count;
    } coal_regs_t;

    coal_regs_t r_q, r_d;

    logic [LEAD_W-1:0] lead_idx;
    logic              lead_any;
    logic [KEY_W-1:0]  lead_key;
    logic [LANES-1:0]  seg_hit;
    logic [LANES-1:0]  pend_after;

    lowest_lane_pick #(.N(LANES)) u_pick (
        .lanes (r_q.pend),
        .idx   (lead_idx),
        .any   (lead_any)
    );

    assign lead_key = r_q.addr[lead_idx][ADDR_W-1:SEG_LSB];

    segment_match #(.N(LANES), .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB)) u_match (
        .addr (r_q.addr),
        .pend (r_q.pend),
        .key  (lead_key),
        .hit  (seg_hit)
    );

    assign pend_after = r_q.pend & ~seg_hit;

    assign req_ready  = (r_q.state == ST_IDLE);
    assign txn_valid  = (r_q.state == ST_ISSUE) && lead_any;
    assign txn_addr   = {lead_key, {SEG_LSB{1'b0}}};
    assign txn_lanes  = seg_hit;
    assign done       = (r_q.state == ST_FINISH);
    assign done_count = r_q.count;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.pend  = req_mask;
                    r_d.count = '0;
                    r_d.state = (|req_mask) ? ST_ISSUE : ST_FINISH;
                end
            end
            ST_ISSUE: begin
                if (txn_ready && lead_any) begin
                    r_d.pend  = pend_after;
                    r_d.count = r_q.count + CNT_W'(1);
                    if (pend_after == '0) begin
                        r_d.state = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: once a request is taken, no second one is taken next cycle
    assert_accept_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: a stalled transaction holds still
    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_lanes)));

    // R8: the leading lane is always part of the presented transaction
    assert_txn_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0));

    // R6: pending lanes never grow while issuing
    assert_pend_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ISSUE) |=> ((r_q.pend & ~$past(r_q.pend)) == '0));

    // R10: served lanes are removed, each lane served once
    assert_served_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> ((r_q.pend & $past(txn_lanes)) == '0));

    // R10: completion is a single-cycle pulse followed by idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R10: completion and issue never overlap; count bounded by lane count
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!txn_valid && (done_count <= CNT_W'(LANES))));

endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;

    localparam int L = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [L*32-1:0] req_addr = '0;
    logic [L-1:0]    req_mask = '0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [31:0]     txn_addr;
    logic [L-1:0]    txn_lanes;
    logic            done;
    logic [5:0]      done_count;

    always #2 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_lanes(txn_lanes),
        .done(done), .done_count(done_count)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] a_in [L];
    logic [31:0] m_in;
    logic [31:0] exp_addr [L];
    logic [31:0] exp_lanes [L];
    int          exp_n;
    logic [31:0] lfsr = 32'hACE1_1234;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return v[0] ? ((v >> 1) ^ 32'h8020_0003) : (v >> 1);
    endfunction

    // Model: groups by address bits [31:7], leader = lowest unserved active lane
    task automatic build_model();
        logic [31:0] pend;
        pend = m_in;
        exp_n = 0;
        while (pend != 0) begin
            int lead = 0;
            logic [31:0] lanes;
            for (int i = L - 1; i >= 0; i--) if (pend[i]) lead = i;
            lanes = 0;
            for (int i = 0; i < L; i++)
                if (pend[i] && (a_in[i][31:7] == a_in[lead][31:7])) lanes[i] = 1'b1;
            exp_addr[exp_n]  = {a_in[lead][31:7], 7'd0};
            exp_lanes[exp_n] = lanes;
            exp_n++;
            pend = pend & ~lanes;
        end
    endtask

    task automatic run_req(input string tag, input bit stall, input int fixed_n);
        int got = 0;
        int iter = 0;
        bit seen = 0;
        bit first = 1;
        bit hold = 0;
        logic [31:0] h_a;
        logic [31:0] h_l;
        build_model();
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = a_in[i];
        req_mask = m_in;
        txn_ready = 1'b0;
        #1 chk(req_ready == 1'b1, "R1 idle ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen && iter < 3000) begin
            txn_ready = stall ? lfsr[0] : 1'b1;
            lfsr = step(lfsr);
            #1;
            if (first) begin
                chk(req_ready == 1'b0, "R1 busy", 64'(req_ready), 64'd0);
                first = 0;
            end
            if (hold) begin
                chk(txn_valid && txn_addr == h_a && txn_lanes == h_l, "R9 hold",
                    {txn_addr, txn_lanes}, {h_a, h_l});
                hold = 0;
            end
            if (done) begin
                seen = 1;
                chk(got == exp_n, "R10 issued count", 64'(got), 64'(exp_n));
                chk(done_count == 6'(exp_n), "R10 done_count", 64'(done_count), 64'(exp_n));
                if (fixed_n >= 0)
                    chk(done_count == 6'(fixed_n), tag, 64'(done_count), 64'(fixed_n));
            end else if (txn_valid) begin
                if (got < exp_n) begin
                    chk(txn_addr == exp_addr[got], "R2 segment address", 64'(txn_addr), 64'(exp_addr[got]));
                    chk(txn_lanes == exp_lanes[got], "R8 lane mask/order", 64'(txn_lanes), 64'(exp_lanes[got]));
                    chk((txn_lanes & ~m_in) == 0, "R6 inactive lane", 64'(txn_lanes), 64'(txn_lanes & m_in));
                end else begin
                    chk(1'b0, "R10 extra transaction", 64'(got), 64'(exp_n));
                end
                if (txn_ready) got++;
                else begin
                    hold = 1; h_a = txn_addr; h_l = txn_lanes;
                end
            end
            @(negedge clk);
            iter++;
        end
        if (!seen) chk(1'b0, "R10 watchdog", 64'(iter), 64'd0);
        txn_ready = 1'b0;
        #1 chk(req_ready == 1'b1 && !done, "R10 ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(txn_valid == 1'b0, "R1 reset txn_valid", 64'(txn_valid), 64'd0);
        chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);

        // R3: aligned contiguous warps
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < L; i++) a_in[i] = 32'(b * 32'h0001_0380) + 32'(b * 128) + 32'(4 * i);
            m_in = '1;
            build_model();
            run_req("R3 single transaction", b[0], 1);
        end

        // R4: every misaligned word offset
        for (int off = 1; off < 32; off++) begin
            for (int i = 0; i < L; i++) a_in[i] = 32'h4000_0000 + 32'(4 * (off + i));
            m_in = '1;
            run_req("R4 two transactions", off[0], 2);
        end

        // R5: fully scattered
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < L; i++) a_in[i] = 32'((L - 1 - i) * 128 * (s + 1)) + 32'(4 * i) + 32'h100;
            m_in = '1;
            run_req("R5 thirty-two transactions", s != 0, 32);
        end

        // R6: masked lanes carry garbage addresses
        for (int i = 0; i < L; i++) a_in[i] = (i < 16) ? 32'h2000 + 32'(4 * i) : 32'(i) * 32'h0123_4567;
        m_in = 32'h0000_FFFF;
        run_req("R6 inactive ignored", 1, 1);
        for (int i = 0; i < L; i++) a_in[i] = i[0] ? 32'hDEAD_0000 + 32'(i * 512) : 32'h8000 + 32'(4 * i);
        m_in = 32'h5555_5555;
        run_req("R6 odd lanes masked", 0, 1);

        // R7: empty mask
        for (int i = 0; i < L; i++) a_in[i] = 32'(i) * 32'h0000_1000;
        m_in = '0;
        run_req("R7 empty request", 0, 0);
        run_req("R7 empty request stalled", 1, 0);

        // R8: strides and interleaved segments
        for (int sh = 0; sh < 6; sh++) begin
            for (int i = 0; i < L; i++) a_in[i] = 32'h10_0000 + 32'((4 * i) << sh);
            m_in = '1;
            run_req("R8 stride", sh[0], (sh <= 0) ? 1 : (L >> (5 - sh)));
        end
        for (int i = 0; i < L; i++) a_in[i] = (i[0] ? 32'h9000 : 32'h1000) + 32'(4 * (L - 1 - i));
        m_in = '1;
        run_req("R8 interleaved", 1, 2);

        // Random near-collision sets with random masks and stalls
        for (int n = 0; n < 200; n++) begin
            for (int i = 0; i < L; i++) begin
                lfsr = step(lfsr);
                a_in[i] = {lfsr[31:30] == 2'b00 ? lfsr[29:20] : 10'd0, 10'd0, lfsr[11:0]} & 32'hFFFF_FFFC;
            end
            lfsr = step(lfsr);
            m_in = (n % 5 == 0) ? '1 : lfsr;
            run_req("R8 random", 1, -1);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule